// File: doc/BRIEF.md
# Multicycle Integer RISC Core

This block is an unpipelined 32-bit processor core for a small integer load-store instruction set. Every instruction passes through a fixed chain of clocked steps: fetch, decode with register read, execute or address calculation, memory access or branch resolution, and write-back. Values that one step produces for a later step are kept in internal holding registers. The program counter, the 32-entry register file and the memories hold the state between instructions.

The core has two memory ports that address bytes and transfer whole words. One port fetches instructions and the other carries load and store traffic. Reads are combinational within the step that uses them, and writes take effect at the clock edge that ends the memory step. The supported instructions are:

- register-register ALU operations;
- register-immediate ALU operations;
- word load;
- word store;
- branch when a register is zero.

Top module: `mc_core`

## Requirements
- R1: While `rst_ni` is low, the core holds the program counter at 0 and sits in the fetch step. No data write is issued, and every general register reads as zero afterwards.
- R2: In the fetch step `imem_re_o` is high and `imem_addr_o` equals the program counter. The program counter changes only at the end of the memory step, where it takes the fetch address plus 4 unless a branch is taken.
- R3: An instruction that writes a register takes 5 cycles from one fetch to the next. A store or a branch takes 4 cycles.
- R4: Register-register form: opcode bits [31:26] = 0, sources in [25:21] and [20:16], destination in [15:11]. The function field [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than.
- R5: Immediate form: source in [25:21], destination in [20:16], a 16-bit immediate in [15:0] that is always sign-extended. The opcode selects the operation: 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, 0x0E xor.
- R6: A load (opcode 0x23) reads the data word at the source register plus the sign-extended immediate and writes it to the register in [20:16].
- R7: A store (opcode 0x2B) writes the register in [20:16] to the source register plus the immediate. `dmem_we_o` is high for exactly one cycle, and the next cycle is a fetch.
- R8: A branch (opcode 0x04) tests the register in [25:21]. If that register is zero, the next fetch address is the fetch address + 4 + (sign-extended immediate × 4). Otherwise it is the fetch address + 4.
- R9: Register 0 always reads as zero. Writes to register 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_re_o | output | 1 | Instruction fetch strobe |
| imem_addr_o | output | 32 | Instruction byte address |
| imem_rdata_i | input | 32 | Instruction word |
| dmem_re_o | output | 1 | Data read strobe (load) |
| dmem_we_o | output | 1 | Data write strobe (store) |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdata_i | input | 32 | Load data |

## Verification
Each step lasts one cycle. A fetch strobe therefore appears 4 or 5 cycles after the previous one, a store's write lands at the edge that ends the fourth cycle of its instruction, and a register result is written at the edge that ends the fifth. The bench samples the ports on the falling edge. It logs every fetch with its cycle number, so that intervals and branch targets are checked against the cycle counts of R3 and R8. Register results become visible only through stores. The program therefore ends by storing every register under test and then parking on a self-branch, and the memory image is compared only after that parking fetch has appeared.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {
    ST_IF  = 3'd0,
    ST_ID  = 3'd1,
    ST_EX  = 3'd2,
    ST_MEM = 3'd3,
    ST_WB  = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_e;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_BRZ  = 6'h04;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_LD   = 6'h23;
  localparam logic [5:0] OP_ST   = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    alu_op_e    op;
    logic       rr;
    logic       ld;
    logic       st;
    logic       br;
    logic       wb;
    logic [4:0] dst;
  } ctrl_t;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [31:0] ir_i,
  output ctrl_t       ctrl_o
);
  logic [5:0] opc, fn;
  assign opc = ir_i[31:26];
  assign fn  = ir_i[5:0];

  always_comb begin
    ctrl_o     = '0;
    ctrl_o.op  = ALU_ADD;
    ctrl_o.dst = ir_i[20:16];
    case (opc)
      OP_RR: begin
        ctrl_o.rr  = 1'b1;
        ctrl_o.wb  = 1'b1;
        ctrl_o.dst = ir_i[15:11];
        case (fn)
          FN_ADD:  ctrl_o.op = ALU_ADD;
          FN_SUB:  ctrl_o.op = ALU_SUB;
          FN_AND:  ctrl_o.op = ALU_AND;
          FN_OR:   ctrl_o.op = ALU_OR;
          FN_XOR:  ctrl_o.op = ALU_XOR;
          FN_SLT:  ctrl_o.op = ALU_SLT;
          default: ctrl_o.wb = 1'b0;  // unknown function: no-op
        endcase
      end
      OP_ADDI: begin ctrl_o.wb = 1'b1; ctrl_o.op = ALU_ADD; end
      OP_SLTI: begin ctrl_o.wb = 1'b1; ctrl_o.op = ALU_SLT; end
      OP_ANDI: begin ctrl_o.wb = 1'b1; ctrl_o.op = ALU_AND; end
      OP_ORI:  begin ctrl_o.wb = 1'b1; ctrl_o.op = ALU_OR;  end
      OP_XORI: begin ctrl_o.wb = 1'b1; ctrl_o.op = ALU_XOR; end
      OP_LD:   begin ctrl_o.wb = 1'b1; ctrl_o.ld = 1'b1; end
      OP_ST:   ctrl_o.st = 1'b1;
      OP_BRZ:  ctrl_o.br = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  da_o,
  output logic [W-1:0]  db_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign da_o = regs_q[ra_i];
  assign db_o = regs_q[rb_i];

  AST_R0_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs_q[$past(wa_i)] == $past(wd_i)); // R4
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            imem_re_o,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_rdata_i,
  output logic            dmem_re_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  localparam int RAW = $clog2(NREGS);

  step_e           step_q;
  logic [XLEN-1:0] pc_q, npc_q, a_q, b_q, imm_q, aluo_q, lmd_q;
  logic [31:0]     ir_q;
  logic            cond_q;

  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_data, rt_data, imm_sx, alu_a, alu_b, alu_y, wb_data;
  logic            rf_we;

  mc_decode u_dec (.ir_i(ir_q), .ctrl_o(ctrl));

  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};

  mc_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (ir_q[21 +: RAW]),
    .rb_i  (ir_q[16 +: RAW]),
    .da_o  (rs_data),
    .db_o  (rt_data),
    .we_i  (rf_we),
    .wa_i  (ctrl.dst[RAW-1:0]),
    .wd_i  (wb_data)
  );

  // branch target shares the adder: npc + (imm << 2)
  assign alu_a = ctrl.br ? npc_q : a_q;
  always_comb begin
    if (ctrl.rr)      alu_b = b_q;
    else if (ctrl.br) alu_b = imm_q << 2;
    else              alu_b = imm_q;
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a_i (alu_a),
    .b_i (alu_b),
    .op_i(ctrl.ld || ctrl.st || ctrl.br ? ALU_ADD : ctrl.op),
    .y_o (alu_y)
  );

  assign rf_we   = (step_q == ST_WB) && ctrl.wb;
  assign wb_data = ctrl.ld ? lmd_q : aluo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IF;
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      aluo_q <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      case (step_q)
        ST_IF: begin
          ir_q   <= imem_rdata_i;
          npc_q  <= pc_q + XLEN'(4);
          step_q <= ST_ID;
        end
        ST_ID: begin
          a_q    <= rs_data;
          b_q    <= rt_data;
          imm_q  <= imm_sx;
          step_q <= ST_EX;
        end
        ST_EX: begin
          aluo_q <= alu_y;
          cond_q <= (a_q == '0);
          step_q <= ST_MEM;
        end
        ST_MEM: begin
          pc_q   <= (ctrl.br && cond_q) ? aluo_q : npc_q;
          if (ctrl.ld) lmd_q <= dmem_rdata_i;
          step_q <= ctrl.wb ? ST_WB : ST_IF;
        end
        default: step_q <= ST_IF;
      endcase
    end
  end

  assign imem_re_o    = (step_q == ST_IF);
  assign imem_addr_o  = pc_q;
  assign dmem_re_o    = (step_q == ST_MEM) && ctrl.ld;
  assign dmem_we_o    = (step_q == ST_MEM) && ctrl.st;
  assign dmem_addr_o  = aluo_q;
  assign dmem_wdata_o = b_q;

  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_re_o |=> step_q == ST_ID); // R3
  AST_WB_AFTER_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == ST_WB |-> $past(step_q) == ST_MEM); // R3
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q != ST_MEM |=> $stable(pc_q)); // R2
  AST_STORE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |=> imem_re_o && !dmem_we_o); // R7
  AST_COND_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == ST_EX |=> cond_q == ($past(a_q) == '0)); // R8
  AST_NO_DUAL_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_we_o && dmem_re_o)); // R7
endmodule

// File: tb/mc_core_tb.sv
module mc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG      = 42;
  localparam int HALT_PC    = 41 * 4;
  localparam int WDOG       = 5000;
  localparam int LOGN       = 512;

  localparam logic [5:0] RR = 6'h00, BZ = 6'h04, ADDI = 6'h08, SLTI = 6'h0A;
  localparam logic [5:0] ORI = 6'h0D, XORI = 6'h0E, LD = 6'h23, ST = 6'h2B;
  localparam logic [5:0] FADD = 6'h20, FSUB = 6'h22, FAND = 6'h24;
  localparam logic [5:0] FXOR = 6'h26, FSLT = 6'h2A;

  function automatic logic [31:0] rr(input logic [5:0] fn, input int rd, input int rs, input int rt);
    logic [31:0] w;
    w = {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    return w;
  endfunction

  function automatic logic [31:0] ri(input logic [5:0] op, input int rt, input int rs, input int imm);
    logic [31:0] w;
    w = {op, rs[4:0], rt[4:0], imm[15:0]};
    return w;
  endfunction

  localparam logic [31:0] PROG [NPROG] = '{
    ri(LD, 1, 0, 0),        // 0  r1 = 5
    ri(LD, 2, 0, 4),        // 1  r2 = -3
    rr(FADD, 3, 1, 2),      // 2
    rr(FSUB, 4, 1, 2),      // 3
    rr(FSLT, 5, 2, 1),      // 4
    rr(FSLT, 6, 1, 2),      // 5
    ri(ADDI, 7, 1, -7),     // 6
    ri(LD, 8, 0, 8),        // 7  r8 = 0x0F0F
    ri(XORI, 9, 8, 'hFF),   // 8
    ri(ORI, 10, 8, 'hF000), // 9  sign-extended
    rr(FAND, 11, 8, 9),     // 10
    ri(ADDI, 0, 1, 9),      // 11 r0 write
    ri(BZ, 0, 6, 2),        // 12 taken -> 15
    ri(ADDI, 12, 0, 111),   // 13
    ri(ADDI, 12, 0, 222),   // 14
    ri(BZ, 0, 5, 1),        // 15 not taken
    ri(ADDI, 13, 0, 77),    // 16
    ri(ADDI, 14, 0, 3),     // 17
    ri(ADDI, 14, 14, -1),   // 18 loop
    ri(ADDI, 15, 15, 2),    // 19
    ri(BZ, 0, 14, 1),       // 20 exit -> 22
    ri(BZ, 0, 0, -4),       // 21 back -> 18
    rr(FXOR, 16, 1, 2),     // 22
    ri(SLTI, 17, 2, -2),    // 23
    ri(ST, 3, 0, 64),  ri(ST, 4, 0, 68),  ri(ST, 5, 0, 72),  ri(ST, 6, 0, 76),
    ri(ST, 7, 0, 80),  ri(ST, 9, 0, 84),  ri(ST, 10, 0, 88), ri(ST, 11, 0, 92),
    ri(ST, 0, 0, 96),  ri(ST, 12, 0, 100), ri(ST, 13, 0, 104), ri(ST, 14, 0, 108),
    ri(ST, 15, 0, 112), ri(ST, 16, 0, 116), ri(ST, 17, 0, 120),
    ri(LD, 18, 0, 64),      // 39
    ri(ST, 18, 0, 124),     // 40
    ri(BZ, 0, 0, -1)        // 41 park
  };

  // expected data words 16..31 and the requirement each one covers
  localparam logic [31:0] EXP [16] = '{
    32'd2, 32'd8, 32'd1, 32'd0, 32'hFFFF_FFFE, 32'h0000_0FF0, 32'hFFFF_FF0F, 32'h0000_0F00,
    32'd0, 32'd0, 32'd77, 32'd0, 32'd6, 32'hFFFF_FFF8, 32'd1, 32'd2
  };
  localparam string EXP_REQ [16] = '{
    "R4", "R4", "R4", "R4", "R5", "R5", "R5", "R4",
    "R9", "R8", "R8", "R8", "R8", "R4", "R5", "R6"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_re, dmem_re, dmem_we;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic [31:0] dmem [64];

  int n_chk = 0, n_fail = 0, cyc = 0, nf = 0, n_wr = 0;
  logic [31:0] f_addr [LOGN];
  int          f_cyc  [LOGN];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mc_core u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .imem_re_o   (imem_re),
    .imem_addr_o (imem_addr),
    .imem_rdata_i(imem_rdata),
    .dmem_re_o   (dmem_re),
    .dmem_we_o   (dmem_we),
    .dmem_addr_o (dmem_addr),
    .dmem_wdata_o(dmem_wdata),
    .dmem_rdata_i(dmem_rdata)
  );

  assign imem_rdata = (imem_addr[7:2] < NPROG) ? PROG[imem_addr[7:2]] : 32'h0;
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (rst_n && dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      n_wr <= n_wr + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (imem_re && nf < LOGN) begin
        f_addr[nf] = imem_addr;
        f_cyc[nf]  = cyc;
        nf = nf + 1;
      end
      cyc = cyc + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int find_fetch(input logic [31:0] a);
    for (int i = 0; i < nf; i++) if (f_addr[i] == a) return i;
    return -1;
  endfunction

  // fetch that follows the first fetch of address a: check its address and spacing
  task automatic chk_next(input string req, input logic [31:0] a, input logic [31:0] nxt, input int gap);
    int k;
    k = find_fetch(a);
    if (k < 0 || k + 1 >= nf) begin
      chk(req, "fetch missing", 32'hDEAD, a);
    end else begin
      chk(req, "next fetch address", f_addr[k+1], nxt);
      chk(req, "fetch spacing", 32'(f_cyc[k+1] - f_cyc[k]), 32'(gap));
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    dmem[0] = 32'd5;
    dmem[1] = 32'hFFFF_FFFD;
    dmem[2] = 32'h0000_0F0F;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'h0);
    chk("R1", "no write in reset", {31'd0, dmem_we}, 32'd0);
    chk("R1", "fetch step in reset", {31'd0, imem_re}, 32'd1);
    @(posedge clk);
    #1 rst_n = 1'b1;

    begin : run
      int w;
      w = 0;
      while (!(nf > 0 && f_addr[nf-1] == HALT_PC) && w < WDOG) begin
        @(negedge clk);
        w++;
      end
      if (w >= WDOG) chk("R3", "watchdog expired", 32'h1, 32'h0);
      repeat (2) @(negedge clk);
    end

    // R2: first fetch at address 0 on the first cycle out of reset
    chk("R2", "first fetch address", f_addr[0], 32'h0);
    chk("R2", "first fetch cycle", 32'(f_cyc[0]), 32'd0);
    // R3/R6: load spacing 5
    chk_next("R3", 32'd0, 32'd4, 5);
    // R3/R7: store spacing 4
    chk_next("R7", 32'd96, 32'd100, 4);
    // R8: taken forward, not taken, taken backward
    chk_next("R8", 32'd48, 32'd60, 4);
    chk_next("R8", 32'd60, 32'd64, 4);
    chk_next("R8", 32'd84, 32'd72, 4);
    // R7: one write strobe cycle per store
    chk("R7", "store write count", 32'(n_wr), 32'd16);
    // R6: loaded source words untouched
    chk("R6", "source word 0", dmem[0], 32'd5);

    // results table walked in order
    for (int i = 0; i < 16; i++) begin
      chk(EXP_REQ[i], $sformatf("data word %0d", 16 + i), dmem[16 + i], EXP[i]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule